// File: doc/BRIEF.md
# Synchronous Serial Receiver

This block receives characters over a clocked synchronous serial line. It works as bus master, generating the serial clock from the base clock through a prescaler and driving it out, or as slave, taking the serial clock from outside. The slave clock is synchronized with two flip-flops before edge detection. Bits are sampled MSB first on rising serial clock edges and shifted into a shift register. When a full character has arrived, it moves into a holding register so the next character can be shifted in at once.

Software writes a control register to pick the prescaler ratio, the master/slave role and a single-character option. A status port reports data-ready, overrun and conflict. A conflict pulse from the bus logic forces the block back to slave. On overrun the holding register keeps the character it already held.

Top module: `sync_rx_unit`

## Requirements
- R1: After reset the control readback is 0x00, the status is 0, the data output is 0, and both `sck_o` and `sck_oe_o` are 0.
- R2: Control layout is bit 7 master select (1 = master), bit 6 single-character stop, and bits 2:0 clock select. Bits 5:3 always read 0. A write whose clock select is 111 leaves the stored clock select unchanged, while the other fields still update.
- R3: In master mode `sck_oe_o` is 1. While a transfer runs, `sck_o` toggles every 128>>cks base clock cycles (full period 4 cycles for cks=110, 8 for cks=101). It rests at 0 whenever no transfer is active.
- R4: Data is sampled MSB first on each rising serial clock. After 8 bits the character appears on `rdata_o` and the status full bit (bit 0) sets. A pulse on `rd_i` clears the full bit.
- R5: In master mode with single stop at 0, clocking continues after each character, so consecutive characters are received without a restart.
- R6: In master mode with single stop at 1, the transfer ends at the first falling serial clock after the character. `active_o` and `sck_o` then stay 0.
- R7: In slave mode the external clock on `sck_i` and data on `sd_i` are received through a two-stage synchronizer. `sck_oe_o` is 0, and the single stop bit has no effect, so several characters arrive back to back.
- R8: When a character completes while full is set and no read happens in that cycle, the overrun flag (status bit 1) sets and `rdata_o` keeps its old value. A status write with bit 1 = 0 clears overrun; a write with bit 1 = 1 leaves it.
- R9: When a read and a character completion fall in the same cycle, the new character loads, full stays 1 and overrun stays 0.
- R10: A `conflict_i` pulse sets the conflict flag (status bit 2), clears the master select, and aborts any master transfer. It takes priority over a control write in the same cycle. A status write with bit 2 = 0 clears the flag.
- R11: A `start_i` pulse in slave mode is ignored: `active_o` stays 0 and `sck_o` does not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control write data |
| ctrl_rdata_o | output | 8 | Control register readback |
| stat_we_i | input | 1 | Status write strobe (flag clear) |
| stat_wdata_i | input | 3 | Status write data |
| stat_o | output | 3 | {conflict, overrun, full} |
| start_i | input | 1 | Start a master reception |
| conflict_i | input | 1 | Conflict error pulse from bus logic |
| rd_i | input | 1 | Holding register read pulse |
| rdata_o | output | DW | Received character |
| active_o | output | 1 | Master transfer in progress |
| sck_i | input | 1 | External serial clock (slave) |
| sck_o | output | 1 | Generated serial clock (master) |
| sck_oe_o | output | 1 | Serial clock output enable |
| sd_i | input | 1 | Serial data in |

## Verification
The holding register read and the completion of a character can land on the same base clock edge. If the read were ordered after the load, the new character would be lost as an overrun. The bench drives the slave clock by hand, so it knows the exact cycle of the eighth sampling edge and raises `rd_i` for that edge. It then expects the new character on `rdata_o`, full still set and overrun clear. A second same-cycle case, a conflict pulse together with a control write that sets master, is judged by reading back a cleared master select.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int CKS_W  = 3;
  localparam int CNT_W  = 7;   // largest half period is 128 cycles
  localparam int CTRL_W = 8;
  localparam int STAT_W = 3;
  localparam logic [CKS_W-1:0] CKS_RSVD = 3'b111;

  // half period minus one, in base clock cycles
  function automatic logic [CNT_W-1:0] half_m1(input logic [CKS_W-1:0] cks);
    logic [CNT_W:0] h;
    h = (CNT_W+1)'(1) << (CNT_W - int'(cks));
    return CNT_W'(h - 1'b1);
  endfunction
endpackage

// File: rtl/sync_rx_clkgen.sv
module sync_rx_clkgen
  import sync_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             halt_req_i,
  input  logic [CKS_W-1:0] cks_i,
  output logic             active_o,
  output logic             sck_o,
  output logic             rise_o
);
  logic [CNT_W-1:0] cnt_q, lim;
  logic active_q, sck_q, pend_q, tick;

  assign lim  = half_m1(cks_i);
  assign tick = active_q && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      pend_q   <= 1'b0;
    end else if (abort_i) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      pend_q   <= 1'b0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        pend_q   <= 1'b0;
      end
    end else begin
      if (halt_req_i) pend_q <= 1'b1;
      if (tick) begin
        cnt_q <= '0;
        sck_q <= ~sck_q;
        // stop on the falling edge after the last character
        if (sck_q && pend_q) begin
          active_q <= 1'b0;
          pend_q   <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign sck_o    = sck_q;
  assign rise_o   = tick && !sck_q;
endmodule

// File: rtl/sync_rx_sync.sv
module sync_rx_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic sd_i,
  output logic rise_o,
  output logic sd_o
);
  logic [SYNC_N:0]   sck_pipe;
  logic [SYNC_N-1:0] sd_pipe;

  for (genvar g = 0; g <= SYNC_N; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sck_pipe[g] <= 1'b0;
      else if (g == 0) sck_pipe[g] <= sck_i;
      else sck_pipe[g] <= sck_pipe[(g == 0) ? 0 : g-1];
    end
    if (g < SYNC_N) begin : g_sd
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sd_pipe[g] <= 1'b0;
        else if (g == 0) sd_pipe[g] <= sd_i;
        else sd_pipe[g] <= sd_pipe[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign rise_o = sck_pipe[SYNC_N-1] && !sck_pipe[SYNC_N];
  assign sd_o   = sd_pipe[SYNC_N-1];
endmodule

// File: rtl/sync_rx_shift.sv
module sync_rx_shift #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          sample_i,
  input  logic          bit_i,
  output logic          done_o,
  output logic [DW-1:0] data_o
);
  localparam int BW = $clog2(DW);

  logic [BW-1:0] cnt_q;
  logic [DW-2:0] sh_q;

  assign done_o = sample_i && (cnt_q == BW'(DW-1));
  assign data_o = {sh_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (sample_i) begin
      sh_q  <= {sh_q[DW-3:0], bit_i};
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sync_rx_unit.sv
module sync_rx_unit
  import sync_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_rdata_o,
  input  logic              stat_we_i,
  input  logic [STAT_W-1:0] stat_wdata_i,
  output logic [STAT_W-1:0] stat_o,
  input  logic              start_i,
  input  logic              conflict_i,
  input  logic              rd_i,
  output logic [DW-1:0]     rdata_o,
  output logic              active_o,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              sd_i
);
  logic             master_q, sstop_q;
  logic [CKS_W-1:0] cks_q;
  logic [DW-1:0]    rdata_q;
  logic             full_q, ovr_q, cfl_q;

  logic abort, start_ok, halt_req, m_active, m_rise, s_rise, s_sd;
  logic sample, bit_in, done, clr;
  logic [DW-1:0] char_data;
  logic unused_bits;

  assign unused_bits = ^{ctrl_wdata_i[5:3], stat_wdata_i[0]};

  assign abort    = conflict_i | (ctrl_we_i & ~ctrl_wdata_i[7]);
  assign start_ok = start_i & master_q & ~abort;
  assign halt_req = done & sstop_q & master_q;
  assign sample   = master_q ? m_rise : s_rise;
  assign bit_in   = master_q ? sd_i : s_sd;
  assign clr      = ctrl_we_i | conflict_i | (master_q & ~m_active);

  sync_rx_clkgen u_clkgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_ok),
    .abort_i    (abort),
    .halt_req_i (halt_req),
    .cks_i      (cks_q),
    .active_o   (m_active),
    .sck_o      (sck_o),
    .rise_o     (m_rise)
  );

  sync_rx_sync #(.SYNC_N(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_i  (sck_i),
    .sd_i   (sd_i),
    .rise_o (s_rise),
    .sd_o   (s_sd)
  );

  sync_rx_shift #(.DW(DW)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .sample_i (sample),
    .bit_i    (bit_in),
    .done_o   (done),
    .data_o   (char_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      master_q <= 1'b0;
      sstop_q  <= 1'b0;
      cks_q    <= '0;
    end else begin
      if (conflict_i) master_q <= 1'b0;
      else if (ctrl_we_i) master_q <= ctrl_wdata_i[7];
      if (ctrl_we_i) begin
        sstop_q <= ctrl_wdata_i[6];
        if (ctrl_wdata_i[2:0] != CKS_RSVD) cks_q <= ctrl_wdata_i[2:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      full_q  <= 1'b0;
      ovr_q   <= 1'b0;
      cfl_q   <= 1'b0;
    end else begin
      if (done && !(full_q && !rd_i)) begin
        rdata_q <= char_data;
        full_q  <= 1'b1;
      end else if (rd_i) begin
        full_q  <= 1'b0;
      end

      if (done && full_q && !rd_i) ovr_q <= 1'b1;
      else if (stat_we_i && !stat_wdata_i[1]) ovr_q <= 1'b0;

      if (conflict_i) cfl_q <= 1'b1;
      else if (stat_we_i && !stat_wdata_i[2]) cfl_q <= 1'b0;
    end
  end

  assign ctrl_rdata_o = {master_q, sstop_q, 3'b000, cks_q};
  assign stat_o       = {cfl_q, ovr_q, full_q};
  assign rdata_o      = rdata_q;
  assign active_o     = m_active;
  assign sck_oe_o     = master_q;
endmodule

// File: rtl/sync_rx_checker.sv
module sync_rx_checker #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          conflict_i,
  input logic [7:0]    ctrl_rdata_o,
  input logic [2:0]    stat_o,
  input logic [DW-1:0] rdata_o,
  input logic          active_o,
  input logic          sck_o,
  input logic          sck_oe_o
);
  assert_reserved_cks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rdata_o[2:0] != 3'b111);

  assert_unused_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rdata_o[5:3] == 3'b000);

  assert_idle_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> !sck_o);

  assert_overrun_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[1]) |-> $stable(rdata_o));

  assert_conflict_slave_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_i |=> (!ctrl_rdata_o[7] && stat_o[2] && !active_o));

  assert_slave_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_rdata_o[7] |-> !active_o);

  assert_slave_no_drive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_rdata_o[7] |-> !sck_oe_o);
endmodule

bind sync_rx_unit sync_rx_checker #(.DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .conflict_i   (conflict_i),
  .ctrl_rdata_o (ctrl_rdata_o),
  .stat_o       (stat_o),
  .rdata_o      (rdata_o),
  .active_o     (active_o),
  .sck_o        (sck_o),
  .sck_oe_o     (sck_oe_o)
);

// File: tb/tb_sync_rx_unit.sv
`timescale 1ns/1ps
module tb_sync_rx_unit;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctrl_we_i = 1'b0;
  logic [7:0] ctrl_wdata_i = '0;
  logic [7:0] ctrl_rdata_o;
  logic       stat_we_i = 1'b0;
  logic [2:0] stat_wdata_i = '0;
  logic [2:0] stat_o;
  logic       start_i = 1'b0, conflict_i = 1'b0, rd_i = 1'b0;
  logic [7:0] rdata_o;
  logic       active_o, sck_o, sck_oe_o;
  logic       sck_i = 1'b0, sd_i = 1'b0;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sync_rx_unit #(.DW(8)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i), .ctrl_rdata_o(ctrl_rdata_o),
    .stat_we_i(stat_we_i), .stat_wdata_i(stat_wdata_i), .stat_o(stat_o),
    .start_i(start_i), .conflict_i(conflict_i), .rd_i(rd_i),
    .rdata_o(rdata_o), .active_o(active_o),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe_o(sck_oe_o), .sd_i(sd_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    ctrl_we_i = 1'b1; ctrl_wdata_i = d;
    @(negedge clk); ctrl_we_i = 1'b0;
  endtask

  task automatic wr_stat(input logic [2:0] d);
    stat_we_i = 1'b1; stat_wdata_i = d;
    @(negedge clk); stat_we_i = 1'b0;
  endtask

  task automatic rd_pulse();
    rd_i = 1'b1; @(negedge clk); rd_i = 1'b0;
  endtask

  task automatic start_pulse();
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
  endtask

  task automatic mrx(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sd_i = b[i];
      @(posedge sck_o); @(negedge clk);
    end
  endtask

  task automatic srx(input logic [7:0] b, input bit rd_last);
    for (int i = 7; i >= 0; i--) begin
      sd_i = b[i];
      @(negedge clk); sck_i = 1'b1;
      @(negedge clk); @(negedge clk);
      if (rd_last && i == 0) rd_i = 1'b1;
      @(negedge clk); rd_i = 1'b0; sck_i = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 ctrl", ctrl_rdata_o, 8'h00);
    chk("R1 stat", stat_o, 3'b000);
    chk("R1 data", rdata_o, 8'h00);
    chk("R1 sck", {sck_o, sck_oe_o}, 2'b00);
  endtask

  task automatic t_ctrl_layout();
    wr_ctrl(8'h06);
    chk("R2 plain", ctrl_rdata_o, 8'h06);
    wr_ctrl(8'hFD);
    chk("R2 unused zero", ctrl_rdata_o, 8'hC5);
    wr_ctrl(8'h7F);
    chk("R2 reserved cks kept", ctrl_rdata_o, 8'h45);
  endtask

  task automatic t_start_slave();
    start_pulse();
    repeat (10) @(negedge clk);
    chk("R11 active", active_o, 1'b0);
    chk("R11 sck", {sck_o, sck_oe_o}, 2'b00);
  endtask

  task automatic t_period();
    realtime t0, t1;
    wr_ctrl(8'h86);
    chk("R3 oe idle", {sck_oe_o, sck_o, active_o}, 3'b100);
    start_pulse();
    @(posedge sck_o); t0 = $realtime;
    @(posedge sck_o); t1 = $realtime;
    @(negedge clk);
    chk("R3 period cks6", int'((t1 - t0) / 4.0), 4);
    wr_ctrl(8'h05);
    wr_ctrl(8'h85);
    start_pulse();
    @(posedge sck_o); t0 = $realtime;
    @(posedge sck_o); t1 = $realtime;
    @(negedge clk);
    chk("R3 period cks5", int'((t1 - t0) / 4.0), 8);
    wr_ctrl(8'h06);
    chk("R3 idle after abort", {sck_o, active_o}, 2'b00);
  endtask

  task automatic t_single_stop();
    wr_ctrl(8'hC6);
    sd_i = 1'b1;
    start_pulse();
    mrx(8'hA5);
    chk("R4 data", rdata_o, 8'hA5);
    chk("R4 full", stat_o, 3'b001);
    repeat (20) @(negedge clk);
    chk("R6 stopped", {active_o, sck_o}, 2'b00);
    chk("R6 no more data", {stat_o, rdata_o}, {3'b001, 8'hA5});
    rd_pulse();
    chk("R4 read clears full", stat_o, 3'b000);
  endtask

  task automatic t_continuous_overrun();
    wr_ctrl(8'h86);
    start_pulse();
    mrx(8'h3C);
    chk("R5 first", rdata_o, 8'h3C);
    rd_pulse();
    mrx(8'hC3);
    chk("R5 second", {stat_o, rdata_o}, {3'b001, 8'hC3});
    chk("R5 still active", active_o, 1'b1);
    mrx(8'h5A);
    chk("R8 overrun keeps", {stat_o, rdata_o}, {3'b011, 8'hC3});
    wr_stat(3'b010);
    chk("R8 write 1 keeps", stat_o[1], 1'b1);
    wr_stat(3'b100);
    chk("R8 write 0 clears", stat_o[1], 1'b0);
    wr_ctrl(8'h06);
    rd_pulse();
  endtask

  task automatic t_slave();
    wr_ctrl(8'h46);
    chk("R7 no drive", sck_oe_o, 1'b0);
    srx(8'h96, 1'b0);
    chk("R7 first", {stat_o, rdata_o}, {3'b001, 8'h96});
    rd_pulse();
    srx(8'h69, 1'b0);
    chk("R7 second despite stop", {stat_o, rdata_o}, {3'b001, 8'h69});
  endtask

  task automatic t_read_collide();
    srx(8'hE7, 1'b1);
    chk("R9 collide", {stat_o, rdata_o}, {3'b001, 8'hE7});
    rd_pulse();
  endtask

  task automatic t_conflict();
    wr_ctrl(8'h86);
    start_pulse();
    repeat (6) @(negedge clk);
    conflict_i = 1'b1; @(negedge clk); conflict_i = 1'b0;
    chk("R10 to slave", {ctrl_rdata_o[7], stat_o[2], active_o, sck_oe_o}, 4'b0100);
    ctrl_we_i = 1'b1; ctrl_wdata_i = 8'h86; conflict_i = 1'b1;
    @(negedge clk); ctrl_we_i = 1'b0; conflict_i = 1'b0;
    chk("R10 wins over write", ctrl_rdata_o, 8'h06);
    wr_stat(3'b000);
    chk("R10 clear", stat_o[2], 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_layout();
    t_start_slave();
    t_period();
    t_single_stop();
    t_continuous_overrun();
    t_slave();
    t_read_collide();
    t_conflict();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400us;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule